// File: doc/BRIEF.md
# Modem Line Change Interrupt Monitor

This block watches the four modem handshake inputs of a serial port: clear-to-send (CTS), data-set-ready (DSR), ring indicator (RI) and data-carrier-detect (DCD). Each input is brought into the core clock domain through a two-flop synchronizer. Any tracked transition is recorded in a sticky change flag, and the block requests a modem interrupt while any flag is pending.

CTS, DSR and DCD record changes in both directions. RI records only a low-to-high transition. Software reads an 8-bit status word that holds the four change flags and the four synchronized line levels. A read, signalled by a one-cycle strobe, clears every pending flag. If a new transition is detected in the same cycle as the read, that flag stays set.

A pending output feeds the serial port's interrupt priority encoder, where this source ranks lowest. A separate enable input gates the interrupt line but has no effect on flag capture.

Top module: `modem_status_irq`

## Requirements
- R1: After a synchronous reset, `rd_data` is 0x00, and `irq_pend` and `irq_out` are low.
- R2: A rising or a falling transition on CTS, DSR or DCD sets that line's change flag. The flags are CTS in bit 0, DSR in bit 1 and DCD in bit 3 of `rd_data`.
- R3: A rising transition on RI sets change flag bit 2. A falling transition on RI sets no flag.
- R4: `rd_data[7:4]` returns the synchronized levels of CTS (bit 4), DSR (bit 5), RI (bit 6) and DCD (bit 7).
- R5: A cycle with `rd_en` high clears all change flags at the next clock edge, unless a transition is detected in that same cycle.
- R6: A transition that is detected in the same cycle as a read leaves its flag set after the read.
- R7: `irq_out` is `irq_pend` AND `irq_en`. `irq_en` has no effect on the capture of the change flags.
- R8: `irq_pend` is high exactly when at least one change flag is set.
- R9: After an input changes, its level appears in `rd_data` after two clock edges. Its change flag appears after three clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| cts_in | input | 1 | Asynchronous clear-to-send line |
| dsr_in | input | 1 | Asynchronous data-set-ready line |
| ri_in | input | 1 | Asynchronous ring indicator line |
| dcd_in | input | 1 | Asynchronous carrier detect line |
| irq_en | input | 1 | Enable for the modem interrupt line |
| rd_en | input | 1 | Status read strobe; clears the change flags |
| rd_data | output | 8 | Levels in [7:4], change flags in [3:0] |
| irq_pend | output | 1 | Pending request to the priority encoder |
| irq_out | output | 1 | Modem interrupt, gated by `irq_en` |

## Verification
The lines are driven with single rising and falling steps on each input, with two inputs changing together, and with an RI pulse whose falling half must leave no trace. These patterns separate the any-edge lines from the rise-only line and show that each flag lands in its own bit. A read strobe placed exactly in the detection cycle of a new edge tells a correct "edge wins over clear" ordering apart from a plain clear. The flag is also sampled one edge before it is due, so that pipeline-latency errors show up. A behavioural model tracks the status word every cycle while the enable is toggled, which shows that the enable gates only the interrupt line.

// File: rtl/msc_pkg.sv
package msc_pkg;

    localparam int LINE_CNT = 4;
    localparam int STAT_W   = 2 * LINE_CNT;

    typedef enum logic [1:0] {
        LINE_CTS = 2'd0,
        LINE_DSR = 2'd1,
        LINE_RI  = 2'd2,
        LINE_DCD = 2'd3
    } line_idx_e;

    // Packed so that cts lands in bit 0 and dcd in bit 3
    typedef struct packed {
        logic dcd;
        logic ri;
        logic dsr;
        logic cts;
    } lines_t;

    typedef struct packed {
        lines_t level;
        lines_t delta;
    } status_t;

    typedef enum logic {
        DET_ANY  = 1'b0,
        DET_RISE = 1'b1
    } det_mode_e;

    // Default detection mode per line: only RI is rise-only
    localparam logic [LINE_CNT-1:0] RISE_ONLY_DEFAULT = 4'b0100;

    function automatic logic edge_seen(det_mode_e mode, logic prev, logic cur);
        if (mode == DET_RISE)
            return cur & ~prev;
        return cur ^ prev;
    endfunction

    function automatic lines_t pack_lines(logic cts, logic dsr, logic ri, logic dcd);
        lines_t l;
        l.cts = cts;
        l.dsr = dsr;
        l.ri  = ri;
        l.dcd = dcd;
        return l;
    endfunction

endpackage

// File: rtl/msc_sync.sv
module msc_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] chain [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= '0;
                else     chain[g] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= '0;
                else     chain[g] <= chain[g-1];
            end
        end
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/msc_edge_det.sv
module msc_edge_det
    import msc_pkg::*;
#(
    parameter int                 WIDTH     = LINE_CNT,
    parameter logic [WIDTH-1:0]   RISE_MASK = RISE_ONLY_DEFAULT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] cur,
    output logic [WIDTH-1:0] hit
);
    logic [WIDTH-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= cur;
    end

    for (genvar i = 0; i < WIDTH; i++) begin : g_line
        localparam det_mode_e MODE = RISE_MASK[i] ? DET_RISE : DET_ANY;
        assign hit[i] = edge_seen(MODE, prev_q[i], cur[i]);
    end
endmodule

// File: rtl/msc_delta_reg.sv
module msc_delta_reg #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] hit,
    input  logic             clr,
    output logic [WIDTH-1:0] delta,
    output logic             pend
);
    logic [WIDTH-1:0] delta_q;
    logic [WIDTH-1:0] delta_d;

    always_comb begin
        delta_d = clr ? '0 : delta_q;
        delta_d = delta_d | hit;   // a new edge outranks the clear
    end

    always_ff @(posedge clk) begin
        if (rst) delta_q <= '0;
        else     delta_q <= delta_d;
    end

    assign delta = delta_q;
    assign pend  = |delta_q;
endmodule

// File: rtl/modem_status_irq.sv
module modem_status_irq
    import msc_pkg::*;
#(
    parameter int               SYNC_STAGES = 2,
    parameter logic [LINE_CNT-1:0] RISE_MASK = RISE_ONLY_DEFAULT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cts_in,
    input  logic              dsr_in,
    input  logic              ri_in,
    input  logic              dcd_in,
    input  logic              irq_en,
    input  logic              rd_en,
    output logic [STAT_W-1:0] rd_data,
    output logic              irq_pend,
    output logic              irq_out
);
    lines_t               raw_lines;
    logic [LINE_CNT-1:0]  lvl_sync;
    logic [LINE_CNT-1:0]  edge_hit;
    logic [LINE_CNT-1:0]  delta_q;
    logic                 pend_w;
    status_t              stat;

    assign raw_lines = pack_lines(cts_in, dsr_in, ri_in, dcd_in);

    msc_sync #(.WIDTH(LINE_CNT), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .din (raw_lines),
        .dout(lvl_sync)
    );

    msc_edge_det #(.WIDTH(LINE_CNT), .RISE_MASK(RISE_MASK)) u_edge (
        .clk(clk),
        .rst(rst),
        .cur(lvl_sync),
        .hit(edge_hit)
    );

    msc_delta_reg #(.WIDTH(LINE_CNT)) u_delta (
        .clk  (clk),
        .rst  (rst),
        .hit  (edge_hit),
        .clr  (rd_en),
        .delta(delta_q),
        .pend (pend_w)
    );

    assign stat.level = lines_t'(lvl_sync);
    assign stat.delta = lines_t'(delta_q);
    assign rd_data    = stat;
    assign irq_pend   = pend_w;
    assign irq_out    = pend_w & irq_en;
endmodule

// File: rtl/msc_checker.sv
module msc_checker (
    input logic       clk,
    input logic       rst,
    input logic       rd_en,
    input logic       irq_en,
    input logic       irq_out,
    input logic       irq_pend,
    input logic [3:0] delta,
    input logic [3:0] lvl,
    input logic [3:0] hit
);
    assert_edge_sets_flag_R6: assert property (@(posedge clk) disable iff (rst)
        (|hit) |=> ((delta & $past(hit)) == $past(hit)));

    assert_read_clears_R5: assert property (@(posedge clk) disable iff (rst)
        (rd_en && hit == 4'b0) |=> (delta == 4'b0));

    assert_ri_rise_only_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(delta[2]) |-> $past(lvl[2]));

    assert_enable_gates_R7: assert property (@(posedge clk) disable iff (rst)
        !irq_en |-> !irq_out);

    assert_pend_from_edge_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_pend) |-> $past(|hit));
endmodule

bind modem_status_irq msc_checker u_chk (
    .clk     (clk),
    .rst     (rst),
    .rd_en   (rd_en),
    .irq_en  (irq_en),
    .irq_out (irq_out),
    .irq_pend(irq_pend),
    .delta   (delta_q),
    .lvl     (lvl_sync),
    .hit     (edge_hit)
);

// File: tb/sim_modem_status_irq.sv
`timescale 1ns/1ps
module sim_modem_status_irq;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cts_in = 0, dsr_in = 0, ri_in = 0, dcd_in = 0;
    logic       irq_en = 0, rd_en = 0;
    logic [7:0] rd_data;
    logic       irq_pend, irq_out;

    int errors = 0;
    int checks = 0;
    bit done   = 0;
    bit model_on = 0;

    always #4 clk = ~clk;  // 125 MHz

    modem_status_irq u0 (
        .clk(clk), .rst(rst),
        .cts_in(cts_in), .dsr_in(dsr_in), .ri_in(ri_in), .dcd_in(dcd_in),
        .irq_en(irq_en), .rd_en(rd_en),
        .rd_data(rd_data), .irq_pend(irq_pend), .irq_out(irq_out)
    );

    // Behavioural model: history of input samples, one per edge
    logic [3:0] smp [$];
    logic [3:0] m_delta;

    function automatic logic [3:0] in_vec();
        return {dcd_in, ri_in, dsr_in, cts_in};
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            smp = {4'b0, 4'b0, 4'b0};
            m_delta = 4'b0;
        end else begin
            logic [3:0] now_l, old_l, hv;
            now_l = smp[1];
            old_l = smp[2];
            hv    = now_l ^ old_l;
            hv[2] = now_l[2] & ~old_l[2];       // RI flags rises only
            m_delta = (rd_en ? 4'b0 : m_delta) | hv;
            smp.push_front(in_vec());
            void'(smp.pop_back());
        end
    end

    task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h at %0t", tag, got, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (model_on && !rst && !done) begin
            check("R4/R5 model rd_data", rd_data, {smp[1], m_delta});
            check("R8 model irq_pend", {7'b0, irq_pend}, {7'b0, |m_delta});
            check("R7 model irq_out", {7'b0, irq_out}, {7'b0, (|m_delta) & irq_en});
        end
    end

    task automatic step(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_read();
        rd_en = 1;
        step(1);
        rd_en = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(8 * 20000);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        step(3);
        rst = 0;
        @(negedge clk);
        check("R1 reset rd_data", rd_data, 8'h00);
        check("R1 reset irq_pend", {7'b0, irq_pend}, 8'h00);
        check("R1 reset irq_out", {7'b0, irq_out}, 8'h00);
        model_on = 1;

        // R9 latency and R2 rising CTS
        cts_in = 1;
        step(2);
        check("R9 level after two edges", rd_data, 8'h10);
        step(1);
        check("R2 CTS rise flag", rd_data, 8'h11);
        check("R8 pend on flag", {7'b0, irq_pend}, 8'h01);
        check("R7 irq_out gated low", {7'b0, irq_out}, 8'h00);
        irq_en = 1;
        #1;
        check("R7 irq_out enabled", {7'b0, irq_out}, 8'h01);
        do_read();
        check("R5 read clears flag", rd_data, 8'h10);
        check("R5 pend cleared", {7'b0, irq_pend}, 8'h00);

        // R2 falling CTS
        cts_in = 0;
        step(3);
        check("R2 CTS fall flag", rd_data, 8'h01);
        do_read();

        // R3 RI rise sets, fall does not
        ri_in = 1;
        step(3);
        check("R3 RI rise flag", rd_data, 8'h44);
        do_read();
        ri_in = 0;
        step(4);
        check("R3 RI fall no flag", rd_data, 8'h00);
        check("R3 RI fall no pend", {7'b0, irq_pend}, 8'h00);

        // R4 and R2 with DSR and DCD together
        dsr_in = 1;
        dcd_in = 1;
        step(3);
        check("R4 DSR/DCD levels and flags", rd_data, 8'hAA);
        do_read();
        check("R4 levels after read", rd_data, 8'hA0);

        // R6 edge in the read cycle survives
        cts_in = 1;
        step(3);
        check("R6 setup CTS flag", rd_data, 8'hB1);
        dsr_in = 0;
        step(2);
        rd_en = 1;
        step(1);
        rd_en = 0;
        check("R6 DSR flag kept, CTS cleared", rd_data, 8'h92);
        do_read();

        // R7 enable low does not block capture
        irq_en = 0;
        dcd_in = 0;
        step(3);
        check("R7 flag captured with enable low", rd_data, 8'h18);
        check("R7 irq_out low with enable low", {7'b0, irq_out}, 8'h00);
        irq_en = 1;
        step(1);
        check("R7 irq_out after enable", {7'b0, irq_out}, 8'h01);
        do_read();
        step(2);
        finish_run();
    end
endmodule